// File: doc/BRIEF.md
# Interleaved Sample SPI Streamer

This block is an SPI slave on the acquisition side of a two-channel sampling system. A host frames each transfer with one low period of chip select. The first byte the host shifts in is a command. The block then shifts out 8-bit unsigned samples held in a two-channel capture memory, using the layout that the command selects.

Two commands produce interleaved dumps: a short one and a long one, each alternating first-channel and second-channel entries. A third command returns a five-byte roll record built from three side-band bytes and the newest pair. A configuration command and the all-zero handshake byte are accepted but return nothing. Any other value leaves the data line low for the rest of the frame.

The capture memory is filled through a plain write port in the system clock domain. The SPI pins are oversampled by the system clock through two-flop synchronizers. SPI mode 3 is used: the clock idles high, the slave changes its output on the falling edge and the host samples it on the rising edge.

Top module: `sspi_streamer`

## Requirements
- R1: Bits travel most significant first, eight per byte. The slave samples `spi_mosi` on rising `spi_sck` edges. `spi_miso` changes only in response to falling `spi_sck` edges, so it is stable at every rising edge.
- R2: The first byte of every frame is the command. `spi_miso` stays 0 while that byte is being shifted in.
- R3: Command 0x03 streams SHORT_BYTES (default 1024) data bytes. Data byte k is entry k/2 of CH1 when k is even and entry k/2 of CH2 when k is odd, so the stream starts with CH1 entry 0.
- R4: Command 0x04 streams LONG_BYTES (default 2048) data bytes in the same alternating order, starting with CH1 entry 0.
- R5: Command 0x02 streams exactly five data bytes in this order: `roll_ref`, CH1 entry 0, CH2 entry 0, `roll_extra`, `roll_status`.
- R6: Command 0x01 (configuration) and command 0x00 (handshake) return no data: `spi_miso` stays 0 for the whole frame. The next frame still accepts a new command.
- R7: Any command value other than 0x00 to 0x04 keeps `spi_miso` at 0 for the rest of the frame.
- R8: Once a command's byte count is used up, every further byte in the same frame reads as 0x00.
- R9: Raising `spi_cs_n` clears the bit and byte counters and the decoded command, even in the middle of a byte. The next frame starts again with a command byte and data byte 0.
- R10: When `cap_we` is high on a clock edge, `cap_data` is written to entry `cap_addr` of channel `cap_ch` (0 = CH1, 1 = CH2). Frames that start after the write return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from host, idles high |
| spi_cs_n | input | 1 | Frame select from host, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| cap_we | input | 1 | Capture memory write enable |
| cap_ch | input | 1 | Channel for the write, 0 = CH1, 1 = CH2 |
| cap_addr | input | AW | Entry index for the write |
| cap_data | input | 8 | Sample byte to write |
| roll_ref | input | 8 | Reference byte, first byte of the roll record |
| roll_extra | input | 8 | Extra byte, fourth byte of the roll record |
| roll_status | input | 8 | Status byte, last byte of the roll record |

## Verification
The assertions assume that each high and low phase of `spi_sck` lasts at least four system clocks. They also assume that `spi_cs_n` changes only while `spi_sck` is high, and that the side-band bytes and the capture memory are not rewritten during a frame that reads them. The stimulus runs the SPI clock at eight system clocks per bit and moves chip select only while SCK idles high. It writes the memory and side-band bytes only between frames. To keep the run short, the bench builds the block with 256-byte and 512-byte dump lengths. Every byte of both dumps is compared against entries computed in the bench, including the zero bytes past each end.

// File: rtl/sspi_pkg.sv
package sspi_pkg;

    typedef enum logic [1:0] {
        FM_SILENT = 2'd0,
        FM_ROLL   = 2'd1,
        FM_DUMP   = 2'd2
    } fmode_e;

    localparam logic [7:0] CMD_HANDSHAKE  = 8'h00;
    localparam logic [7:0] CMD_CONFIG     = 8'h01;
    localparam logic [7:0] CMD_ROLL       = 8'h02;
    localparam logic [7:0] CMD_DUMP_SHORT = 8'h03;
    localparam logic [7:0] CMD_DUMP_LONG  = 8'h04;

    localparam int ROLL_BYTES = 5;

endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, meta_d;
        logic stab_q, stab_d;

        always_comb begin
            meta_d = async_i[g];
            stab_d = meta_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
        end

        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/sspi_capmem.sv
module sspi_capmem #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          ch,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rd_ch1,
    output logic [7:0]    rd_ch2
);

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic [7:0] mem [DEPTH];
        logic [7:0] rd_q;
        logic       hit;

        assign hit = we && (ch == c[0]);

        always_ff @(posedge clk) begin
            if (hit) begin
                mem[waddr] <= wdata;
            end
            rd_q <= mem[raddr];
        end
    end

    assign rd_ch1 = g_ch[0].rd_q;
    assign rd_ch2 = g_ch[1].rd_q;

    // R10: writes land on an existing entry
    assert_wr_addr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/sspi_frame.sv
module sspi_frame
    import sspi_pkg::*;
#(
    parameter int SHORT_BYTES = 1024,
    parameter int LONG_BYTES  = 2048,
    parameter int AW          = 10,
    localparam int IW         = $clog2(LONG_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    input  logic [7:0]    rd_ch1,
    input  logic [7:0]    rd_ch2,
    input  logic [7:0]    roll_ref,
    input  logic [7:0]    roll_extra,
    input  logic [7:0]    roll_status,
    output logic [AW-1:0] raddr,
    output logic          miso
);

    typedef struct packed {
        logic          sck_prev;
        logic          in_cmd;
        logic [2:0]    rx_cnt;
        logic [2:0]    tx_cnt;
        logic [7:0]    rx_sh;
        logic [7:0]    tx_sh;
        fmode_e        mode;
        logic [IW-1:0] idx;
        logic [IW-1:0] limit;
        logic          miso;
    } fstate_t;

    fstate_t st_q, st_d;

    logic       rise, fall, have_data;
    logic [7:0] cmd_byte, pick, load;

    assign rise     = sck_s && !st_q.sck_prev;
    assign fall     = !sck_s && st_q.sck_prev;
    assign cmd_byte = {st_q.rx_sh[6:0], mosi_s};

    // Address for the entry the next data byte needs
    assign raddr = (st_q.mode == FM_DUMP) ? st_q.idx[AW:1] : '0;

    always_comb begin
        pick = 8'h00;
        unique case (st_q.mode)
            FM_ROLL: begin
                case (st_q.idx)
                    IW'(0):  pick = roll_ref;
                    IW'(1):  pick = rd_ch1;
                    IW'(2):  pick = rd_ch2;
                    IW'(3):  pick = roll_extra;
                    IW'(4):  pick = roll_status;
                    default: pick = 8'h00;
                endcase
            end
            FM_DUMP:  pick = st_q.idx[0] ? rd_ch2 : rd_ch1;
            default:  pick = 8'h00;
        endcase
    end

    assign have_data = (st_q.mode != FM_SILENT) && (st_q.idx < st_q.limit);
    assign load      = have_data ? pick : 8'h00;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        if (cs_n_s) begin
            st_d.in_cmd = 1'b1;
            st_d.rx_cnt = '0;
            st_d.tx_cnt = '0;
            st_d.rx_sh  = '0;
            st_d.tx_sh  = '0;
            st_d.mode   = FM_SILENT;
            st_d.idx    = '0;
            st_d.limit  = '0;
            st_d.miso   = 1'b0;
        end else begin
            if (rise && st_q.in_cmd) begin
                st_d.rx_sh  = cmd_byte;
                st_d.rx_cnt = st_q.rx_cnt + 3'd1;
                if (st_q.rx_cnt == 3'd7) begin
                    st_d.in_cmd = 1'b0;
                    st_d.idx    = '0;
                    case (cmd_byte)
                        CMD_ROLL: begin
                            st_d.mode  = FM_ROLL;
                            st_d.limit = IW'(ROLL_BYTES);
                        end
                        CMD_DUMP_SHORT: begin
                            st_d.mode  = FM_DUMP;
                            st_d.limit = IW'(SHORT_BYTES);
                        end
                        CMD_DUMP_LONG: begin
                            st_d.mode  = FM_DUMP;
                            st_d.limit = IW'(LONG_BYTES);
                        end
                        default: begin
                            st_d.mode  = FM_SILENT;
                            st_d.limit = '0;
                        end
                    endcase
                end
            end
            if (fall) begin
                if (st_q.tx_cnt == 3'd0) begin
                    st_d.miso  = load[7];
                    st_d.tx_sh = {load[6:0], 1'b0};
                    if (have_data) begin
                        st_d.idx = st_q.idx + IW'(1);
                    end
                end else begin
                    st_d.miso  = st_q.tx_sh[7];
                    st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
                end
                st_d.tx_cnt = st_q.tx_cnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sck_prev <= 1'b1;
            st_q.in_cmd   <= 1'b1;
            st_q.mode     <= FM_SILENT;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso = st_q.miso;

    // R1: output moves only after a falling SCK edge
    assert_miso_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !fall) |=> $stable(st_q.miso));

    // R2: nothing is driven while the command byte arrives
    assert_cmd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_cmd |-> !st_q.miso);

    // R6 and R7: silent commands keep the line low
    assert_silent_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == FM_SILENT) |-> !st_q.miso);

    // R8: the byte index never passes the command's length
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= st_q.limit);

    // R9: a released chip select clears the framing state
    assert_frame_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (st_q.idx == '0 && st_q.tx_cnt == 3'd0 && st_q.in_cmd));

endmodule

// File: rtl/sspi_streamer.sv
module sspi_streamer #(
    parameter int SHORT_BYTES = 1024,
    parameter int LONG_BYTES  = 2048,
    localparam int DEPTH      = LONG_BYTES / 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic          cap_we,
    input  logic          cap_ch,
    input  logic [AW-1:0] cap_addr,
    input  logic [7:0]    cap_data,
    input  logic [7:0]    roll_ref,
    input  logic [7:0]    roll_extra,
    input  logic [7:0]    roll_status
);

    logic [2:0]    pins_s;
    logic [AW-1:0] raddr;
    logic [7:0]    rd_ch1, rd_ch2;

    sspi_sync #(
        .W       (3),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sck, spi_cs_n, spi_mosi}),
        .sync_o  (pins_s)
    );

    sspi_capmem #(
        .DEPTH (DEPTH)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cap_we),
        .ch     (cap_ch),
        .waddr  (cap_addr),
        .wdata  (cap_data),
        .raddr  (raddr),
        .rd_ch1 (rd_ch1),
        .rd_ch2 (rd_ch2)
    );

    sspi_frame #(
        .SHORT_BYTES (SHORT_BYTES),
        .LONG_BYTES  (LONG_BYTES),
        .AW          (AW)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (pins_s[2]),
        .cs_n_s      (pins_s[1]),
        .mosi_s      (pins_s[0]),
        .rd_ch1      (rd_ch1),
        .rd_ch2      (rd_ch2),
        .roll_ref    (roll_ref),
        .roll_extra  (roll_extra),
        .roll_status (roll_status),
        .raddr       (raddr),
        .miso        (spi_miso)
    );

endmodule

// File: tb/sspi_streamer_bench.sv
module sspi_streamer_bench;

    localparam int SHORT = 256;
    localparam int LONG  = 512;
    localparam int DEPTH = LONG / 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic          miso;
    logic          we = 1'b0, ch = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rref = 8'h5C, rext = 8'h3A, rstat = 8'h81;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sspi_streamer #(
        .SHORT_BYTES (SHORT),
        .LONG_BYTES  (LONG)
    ) u_sspi_streamer (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .cap_we      (we),
        .cap_ch      (ch),
        .cap_addr    (waddr),
        .cap_data    (wdata),
        .roll_ref    (rref),
        .roll_extra  (rext),
        .roll_status (rstat)
    );

    function automatic logic [7:0] f_ch1(int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [7:0] f_ch2(int i);
        return 8'(i * 91 + 200) ^ 8'hC3;
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sck   = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic frame_open(input logic [7:0] cmd, string tag);
        logic [7:0] rx;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        xbyte(cmd, rx);
        check8({tag, " R2 command byte quiet"}, rx, 8'h00);
    endtask

    task automatic frame_close();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            we = 1'b1; ch = 1'b0; waddr = AW'(i); wdata = f_ch1(i);
            @(negedge clk);
            ch = 1'b1; wdata = f_ch2(i);
        end
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check8("reset R9 miso low", {7'd0, miso}, 8'h00);
    endtask

    task automatic t_handshake();
        logic [7:0] rx;
        frame_open(8'h00, "handshake");
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, rx);
            check8("R6 handshake no data", rx, 8'h00);
        end
        frame_close();
    endtask

    task automatic t_config();
        logic [7:0] rx;
        frame_open(8'h01, "config");
        for (int k = 0; k < 3; k++) begin
            xbyte(8'hA5, rx);
            check8("R6 config no data", rx, 8'h00);
        end
        frame_close();
    endtask

    task automatic t_roll(input logic [7:0] c1, input logic [7:0] c2, string tag);
        logic [7:0] rx;
        logic [7:0] exp [5];
        exp[0] = rref; exp[1] = c1; exp[2] = c2; exp[3] = rext; exp[4] = rstat;
        frame_open(8'h02, tag);
        for (int k = 0; k < 5; k++) begin
            xbyte(8'h00, rx);
            check8({tag, " R5 roll record"}, rx, exp[k]);
        end
        for (int k = 0; k < 2; k++) begin
            xbyte(8'h00, rx);
            check8({tag, " R8 past roll end"}, rx, 8'h00);
        end
        frame_close();
    endtask

    task automatic t_dump(input logic [7:0] cmd, input int n, string tag);
        logic [7:0] rx;
        frame_open(cmd, tag);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx);
            check8(tag, rx, (k % 2 == 0) ? f_ch1(k / 2) : f_ch2(k / 2));
        end
        for (int k = 0; k < 2; k++) begin
            xbyte(8'h00, rx);
            check8({tag, " R8 past dump end"}, rx, 8'h00);
        end
        frame_close();
    endtask

    task automatic t_unknown();
        logic [7:0] rx;
        frame_open(8'h7E, "unknown");
        for (int k = 0; k < 4; k++) begin
            xbyte(8'hFF, rx);
            check8("R7 unknown command", rx, 8'h00);
        end
        frame_close();
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        frame_open(8'h04, "abort");
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, rx);
            check8("R4 before abort", rx, (k % 2 == 0) ? f_ch1(k / 2) : f_ch2(k / 2));
        end
        for (int b = 0; b < 3; b++) begin
            @(negedge clk); sck = 1'b0;
            repeat (HALF) @(negedge clk); sck = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
        frame_close();
        frame_open(8'h03, "after abort");
        for (int k = 0; k < 4; k++) begin
            xbyte(8'h00, rx);
            check8("R9 restart at byte 0", rx, (k % 2 == 0) ? f_ch1(k / 2) : f_ch2(k / 2));
        end
        frame_close();
    endtask

    task automatic t_rewrite();
        @(negedge clk);
        we = 1'b1; ch = 1'b0; waddr = '0; wdata = 8'hE7;
        @(negedge clk);
        ch = 1'b1; wdata = 8'h19;
        @(negedge clk);
        we = 1'b0;
        rstat = 8'h42;
        t_roll(8'hE7, 8'h19, "R10 rewrite");
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_handshake();
        t_roll(f_ch1(0), f_ch2(0), "after handshake R6");
        t_config();
        t_unknown();
        t_dump(8'h03, SHORT, "R3 short dump R1");
        t_dump(8'h04, LONG, "R4 long dump");
        t_abort();
        t_rewrite();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule